// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level page table that sits in ordinary memory. A requester presents the virtual address and the kind of access (read, write or execute). The walker reads one word from the outer table and then one word from the inner table through a simple read port. It returns either the physical address or a fault with a cause code. Two inputs describe the table: a base address for the outer table and a length that bounds the outer index.

The virtual address splits into three fields, from the top bit down: a 10-bit outer index in bits [31:22], a 10-bit inner index in bits [21:12] and a 12-bit page offset in bits [11:0]. Pages are therefore 4 KiB.

Every table entry is one 32-bit word laid out as follows:
- bits [31:12] hold a frame number;
- bit 3 grants execute, bit 2 grants write and bit 1 grants read;
- bit 0 marks the entry valid;
- bits [11:4] are ignored.

An outer entry's frame number gives the page that holds the inner table. An inner entry's frame number gives the data page.

The memory port works as follows. `mem_req` is high for exactly one cycle with `mem_addr`. The memory answers one or more cycles later by pulsing `mem_rvalid` with `mem_rdata`.

Top module: `pt_walker`

## Requirements
- R1: A walk that succeeds gives `resp_paddr` = {inner entry bits [31:12], virtual address bits [11:0]}, with `resp_fault`=0 and `resp_cause`=0.
- R2: The first read of a walk is at address `ptbr` + 4 × outer index.
- R3: The second read is at address (outer entry frame × 4096) + 4 × inner index.
- R4: If the outer index is greater than or equal to `ptlr`, the walker raises a fault with cause 1 (length) and issues no memory read. The largest legal index, `ptlr`−1, goes on to the table.
- R5: An outer entry whose bit 0 is clear raises a fault with cause 2 after exactly one read.
- R6: An inner entry whose bit 0 is clear raises a fault with cause 3 after two reads.
- R7: For a valid inner entry, the access type selects the permission bit that must be set. `req_acc`=0 (read) needs bit 1, `req_acc`=1 (write) needs bit 2 and `req_acc`=2 (execute) needs bit 3. `req_acc`=3 is always refused. A refused access raises a fault with cause 4.
- R8: A successful walk makes exactly two reads. Each `mem_req` lasts one cycle, and the walker waits for `mem_rvalid` before it goes on.
- R9: `req_ready` is high only while the walker is idle. A `req_valid` seen while it is busy is ignored: it causes no extra read and no extra response.
- R10: `resp_valid` is a one-cycle pulse. On a fault, `resp_paddr` is 0 and `resp_cause` is nonzero.
- R11: After reset, `req_ready` is 1 and both `resp_valid` and `mem_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ptbr | input | 32 | Byte address of the outer table |
| ptlr | input | 11 | Number of legal outer indices |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and accepting a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| mem_req | output | 1 | One-cycle read strobe |
| mem_addr | output | 32 | Byte address of the table word being read |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Table word returned |
| resp_valid | output | 1 | Result pulse |
| resp_fault | output | 1 | Translation failed |
| resp_cause | output | 3 | 0 none, 1 length, 2 outer invalid, 3 inner invalid, 4 protection |
| resp_paddr | output | 32 | Physical address, 0 on a fault |

## Verification
The case hardest to reach from the ports is a request that arrives while a walk is already running. The bench holds `req_valid` high with a different address through a whole walk. It then checks three things: only one response comes back, it belongs to the first address, and the read count rises by exactly two. Reads that skip the memory (length faults) and reads that stop after the outer level are told apart by counting `mem_req` pulses in the bench's memory model. The model also varies its latency from one read to the next.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int VA_W   = 32;
    localparam int OFF_W  = 12;
    localparam int IDX_W  = 10;
    localparam int FRM_W  = VA_W - OFF_W;
    localparam int LEN_W  = IDX_W + 1;
    localparam int WSH    = 2;
    localparam int PAD_W  = VA_W - IDX_W - WSH;

    typedef enum logic [1:0] {
        ACC_RD  = 2'd0,
        ACC_WR  = 2'd1,
        ACC_EX  = 2'd2,
        ACC_RSV = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        CAUSE_NONE  = 3'd0,
        CAUSE_LEN   = 3'd1,
        CAUSE_OUTER = 3'd2,
        CAUSE_INNER = 3'd3,
        CAUSE_PROT  = 3'd4
    } cause_e;

    typedef struct packed {
        logic [FRM_W-1:0]   frame;
        logic [OFF_W-5:0]   spare;
        logic               x;
        logic               w;
        logic               r;
        logic               v;
    } pte_t;

    typedef struct packed {
        logic [IDX_W-1:0] outer;
        logic [IDX_W-1:0] inner;
        logic [OFF_W-1:0] off;
    } va_t;

    function automatic logic perm_ok(pte_t e, acc_e a);
        case (a)
            ACC_RD:  return e.r;
            ACC_WR:  return e.w;
            ACC_EX:  return e.x;
            default: return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/ptw_addr_calc.sv
module ptw_addr_calc
    import ptw_pkg::*;
(
    input  logic                 level,
    input  logic [VA_W-1:0]      base,
    input  logic [FRM_W-1:0]     tbl_frame,
    input  logic [IDX_W-1:0]     outer_idx,
    input  logic [IDX_W-1:0]     inner_idx,
    output logic [VA_W-1:0]      addr
);
    logic [VA_W-1:0] start;
    logic [VA_W-1:0] step;

    always_comb begin
        if (level) begin
            start = {tbl_frame, {OFF_W{1'b0}}};
            step  = {{PAD_W{1'b0}}, inner_idx, {WSH{1'b0}}};
        end else begin
            start = base;
            step  = {{PAD_W{1'b0}}, outer_idx, {WSH{1'b0}}};
        end
        addr = start + step;
    end
endmodule

// File: rtl/ptw_entry_check.sv
module ptw_entry_check
    import ptw_pkg::*;
(
    input  logic             level,
    input  logic [VA_W-1:0]  word,
    input  acc_e             acc,
    output logic             bad,
    output cause_e           cause,
    output logic [FRM_W-1:0] frame
);
    pte_t e;

    always_comb begin
        e     = pte_t'(word);
        frame = e.frame;
        bad   = 1'b0;
        cause = CAUSE_NONE;
        if (!e.v) begin
            bad   = 1'b1;
            cause = level ? CAUSE_INNER : CAUSE_OUTER;
        end else if (level && !perm_ok(e, acc)) begin
            bad   = 1'b1;
            cause = CAUSE_PROT;
        end
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       ptbr,
    input  logic [10:0]       ptlr,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_vaddr,
    input  logic [1:0]        req_acc,
    output logic              mem_req,
    output logic [31:0]       mem_addr,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              resp_valid,
    output logic              resp_fault,
    output logic [2:0]        resp_cause,
    output logic [31:0]       resp_paddr
);
    typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_RESP} st_e;

    st_e              st;
    va_t              va_q;
    acc_e             acc_q;
    logic             lvl_q;
    logic [FRM_W-1:0] tbl_q;
    logic             fault_q;
    cause_e           cause_q;
    logic [VA_W-1:0]  paddr_q;

    va_t              va_in;
    logic             chk_bad;
    cause_e           chk_cause;
    logic [FRM_W-1:0] chk_frame;

    assign va_in = va_t'(req_vaddr);

    ptw_addr_calc u_addr (
        .level     (lvl_q),
        .base      (ptbr),
        .tbl_frame (tbl_q),
        .outer_idx (va_q.outer),
        .inner_idx (va_q.inner),
        .addr      (mem_addr)
    );

    ptw_entry_check u_chk (
        .level (lvl_q),
        .word  (mem_rdata),
        .acc   (acc_q),
        .bad   (chk_bad),
        .cause (chk_cause),
        .frame (chk_frame)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            va_q    <= '0;
            acc_q   <= ACC_RD;
            lvl_q   <= 1'b0;
            tbl_q   <= '0;
            fault_q <= 1'b0;
            cause_q <= CAUSE_NONE;
            paddr_q <= '0;
        end else begin
            case (st)
                S_IDLE: if (req_valid) begin
                    va_q    <= va_in;
                    acc_q   <= acc_e'(req_acc);
                    lvl_q   <= 1'b0;
                    fault_q <= 1'b0;
                    cause_q <= CAUSE_NONE;
                    paddr_q <= '0;
                    if ({1'b0, va_in.outer} >= ptlr) begin
                        fault_q <= 1'b1;
                        cause_q <= CAUSE_LEN;
                        st      <= S_RESP;
                    end else begin
                        st      <= S_ISSUE;
                    end
                end
                S_ISSUE: st <= S_WAIT;
                S_WAIT: if (mem_rvalid) begin
                    if (chk_bad) begin
                        fault_q <= 1'b1;
                        cause_q <= chk_cause;
                        st      <= S_RESP;
                    end else if (!lvl_q) begin
                        tbl_q   <= chk_frame;
                        lvl_q   <= 1'b1;
                        st      <= S_ISSUE;
                    end else begin
                        paddr_q <= {chk_frame, va_q.off};
                        st      <= S_RESP;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign req_ready  = (st == S_IDLE);
    assign mem_req    = (st == S_ISSUE);
    assign resp_valid = (st == S_RESP);
    assign resp_fault = fault_q;
    assign resp_cause = cause_q;
    assign resp_paddr = paddr_q;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        mem_req,
    input logic        resp_valid,
    input logic        resp_fault,
    input logic [2:0]  resp_cause,
    input logic [31:0] resp_paddr
);
    // R8
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);
    // R9
    busy_no_ready_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !req_ready);
    // R9
    accept_drops_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);
    // R10
    resp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid);
    // R10
    fault_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_fault) |-> (resp_cause != 3'd0 && resp_paddr == 32'd0));
    // R1
    ok_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_fault) |-> (resp_cause == 3'd0));
endmodule

bind pt_walker pt_walker_chk u_walker_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .mem_req    (mem_req),
    .resp_valid (resp_valid),
    .resp_fault (resp_fault),
    .resp_cause (resp_cause),
    .resp_paddr (resp_paddr)
);

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] ptbr = 32'h0;
    logic [10:0] ptlr = 11'd16;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = 32'h0;
    logic [1:0]  req_acc = 2'd0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = 32'h0;
    logic        resp_valid;
    logic        resp_fault;
    logic [2:0]  resp_cause;
    logic [31:0] resp_paddr;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    pt_walker u0 (
        .clk(clk), .rst(rst), .ptbr(ptbr), .ptlr(ptlr),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_acc(req_acc),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .resp_valid(resp_valid), .resp_fault(resp_fault),
        .resp_cause(resp_cause), .resp_paddr(resp_paddr)
    );

    // memory model: 4 pages of words, latency varies 1..3 cycles
    logic [31:0] mem [0:4095];
    int          nreads = 0;
    logic        pend = 1'b0;
    int          cnt = 0;
    logic [31:0] aq = 32'h0;

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_req) begin
            pend   <= 1'b1;
            cnt    <= nreads % 3;
            aq     <= mem_addr;
            nreads <= nreads + 1;
        end else if (pend) begin
            if (cnt == 0) begin
                pend       <= 1'b0;
                mem_rvalid <= 1'b1;
                mem_rdata  <= (aq[31:14] == 18'd0) ? mem[{aq[13:12], aq[11:2]}] : 32'h0;
            end else begin
                cnt <= cnt - 1;
            end
        end
    end

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    logic [2:0]  r_cause;
    logic        r_fault;
    logic [31:0] r_paddr;
    int          r_reads;
    logic        r_ready_hi;
    logic        r_timeout;

    task automatic walk(input logic [31:0] va, input logic [1:0] acc, input logic hold_busy);
        int start;
        int extra;
        logic got;
        start      = nreads;
        r_ready_hi = 1'b0;
        r_timeout  = 1'b0;
        got        = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_acc = acc;
        @(negedge clk);
        if (hold_busy) begin
            req_vaddr = 32'h0000_1FFF; req_acc = 2'd1;
        end else begin
            req_valid = 1'b0;
        end
        for (int i = 0; i < 100 && !got; i++) begin
            if (resp_valid) begin
                got = 1'b1;
                r_cause = resp_cause; r_fault = resp_fault; r_paddr = resp_paddr;
            end else begin
                if (req_ready) r_ready_hi = 1'b1;
                @(negedge clk);
            end
        end
        req_valid = 1'b0;
        if (!got) r_timeout = 1'b1;
        extra = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (resp_valid) extra++;
        end
        r_reads = nreads - start;
        if (extra != 0) r_timeout = 1'b1;
    endtask

    localparam int NV = 14;
    localparam logic [31:0] V_VA [NV] = '{
        32'h0000_0123, 32'h0000_0123, 32'h0000_1FFF, 32'h0000_1FFF,
        32'h0000_2000, 32'h0000_2000, 32'h0000_3000, 32'h0040_0000,
        32'h00BF_FABC, 32'h03C0_0000, 32'h0400_0000, 32'hFFC0_0000,
        32'h0000_4000, 32'h0000_1000};
    localparam logic [1:0] V_ACC [NV] = '{
        2'd0, 2'd1, 2'd1, 2'd2, 2'd2, 2'd0, 2'd0, 2'd0,
        2'd1, 2'd0, 2'd0, 2'd0, 2'd0, 2'd3};
    localparam logic [2:0] V_CAUSE [NV] = '{
        3'd0, 3'd4, 3'd0, 3'd4, 3'd0, 3'd4, 3'd3, 3'd2,
        3'd0, 3'd2, 3'd1, 3'd1, 3'd4, 3'd4};
    localparam logic [31:0] V_PA [NV] = '{
        32'hABCD_E123, 32'h0, 32'h1234_5FFF, 32'h0, 32'h0F0F_0000, 32'h0, 32'h0, 32'h0,
        32'hFFFF_FABC, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0};
    localparam int V_RD [NV] = '{2, 2, 2, 2, 2, 2, 2, 1, 2, 1, 0, 0, 2, 2};
    // tags: R1 R7 R1 R7 R1 R7 R6 R5 R3 R5 R4 R4 R7 R7

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
        mem[{2'd0, 10'd0}]    = 32'h0000_1001;   // outer 0 -> page 1
        mem[{2'd0, 10'd2}]    = 32'h0000_2001;   // outer 2 -> page 2
        mem[{2'd1, 10'd0}]    = 32'hABCD_E003;   // read only
        mem[{2'd1, 10'd1}]    = 32'h1234_5007;   // read-write
        mem[{2'd1, 10'd2}]    = 32'h0F0F_0009;   // execute only
        mem[{2'd1, 10'd4}]    = 32'h5555_5001;   // valid, no rights
        mem[{2'd2, 10'd1023}] = 32'hFFFF_F00F;   // all rights
        mem[{2'd3, 10'd5}]    = 32'h0000_1001;   // alt table at 0x3000

        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        check(req_ready == 1'b1, "R11 ready", {31'd0, req_ready}, 32'd1);
        check(resp_valid == 1'b0 && mem_req == 1'b0, "R11 idle outputs",
              {30'd0, resp_valid, mem_req}, 32'd0);

        for (int k = 0; k < NV; k++) begin
            walk(V_VA[k], V_ACC[k], 1'b0);
            check(!r_timeout, $sformatf("vec%0d response", k), {31'd0, r_timeout}, 32'd0);
            check(r_cause == V_CAUSE[k], $sformatf("vec%0d R4/R5/R6/R7 cause", k),
                  {29'd0, r_cause}, {29'd0, V_CAUSE[k]});
            check(r_fault == (V_CAUSE[k] != 3'd0), $sformatf("vec%0d R10 fault", k),
                  {31'd0, r_fault}, {31'd0, V_CAUSE[k] != 3'd0});
            check(r_paddr == V_PA[k], $sformatf("vec%0d R1 paddr", k), r_paddr, V_PA[k]);
            check(r_reads == V_RD[k], $sformatf("vec%0d R8 reads", k), r_reads, V_RD[k]);
            check(!r_ready_hi, $sformatf("vec%0d R9 ready low", k), {31'd0, r_ready_hi}, 32'd0);
        end

        // R2: nonzero table base, outer index 5 at 0x3000 + 20
        ptbr = 32'h0000_3000;
        walk(32'h0140_1ABC, 2'd1, 1'b0);
        check(r_paddr == 32'h1234_5ABC && !r_fault, "R2 base offset", r_paddr, 32'h1234_5ABC);
        ptbr = 32'h0;

        // R4: zero length faults every index with no read
        ptlr = 11'd0;
        walk(32'h0000_0123, 2'd0, 1'b0);
        check(r_cause == 3'd1 && r_reads == 0, "R4 zero length", {29'd0, r_cause}, 32'd1);
        // R4: largest legal index ptlr-1 proceeds
        ptlr = 11'd3;
        walk(32'h00BF_FABC, 2'd1, 1'b0);
        check(r_paddr == 32'hFFFF_FABC && r_reads == 2, "R4 last legal index", r_paddr, 32'hFFFF_FABC);
        ptlr = 11'd16;

        // R9: request held during a walk is ignored
        walk(32'h0000_0123, 2'd0, 1'b1);
        check(r_paddr == 32'hABCD_E123, "R9 busy result", r_paddr, 32'hABCD_E123);
        check(r_reads == 2 && !r_timeout, "R9 busy no extra walk", r_reads, 32'd2);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule